// File: doc/BRIEF.md
# Debug Exception Vector-Catch Controller

This block holds the debug exception and monitor control word of a small processor core and turns vector-catch matches into halt requests. Software or a debugger writes the word through a 32-bit register port. The word holds a trace enable, four monitor control bits and eight per-fault catch enables. The remaining bit positions are reserved.

A catch match happens when an exception entry reports a fault class whose enable is set, or when a core reset occurs while the core-reset catch is enabled. A match raises a halt request. The request is held until the core signals an instruction boundary, which means the core stops on the first handler instruction. Two cases need extra handling. A fault during the vector fetch or stack push of a caught exception retargets the halt onto that fault's handler, and this is flagged. While such a fault is in progress, a late-arriving interrupt is suppressed.

The control word uses three reset levels. Power-on reset clears the whole word. System reset leaves the word unchanged. Core reset clears only the monitor bits.

Top module: `dbg_vcatch_ctrl`

## Requirements
- R1: Writable bits are 24, 19..16, 10..4 and 0. A write stores `reg_wdata_i` masked to these bits, and every other bit reads 0 whatever is written.
- R2: While `rst_ni` is low, the register reads 0 and `halt_req_o`, `halt_fault_o`, `trace_en_o`, `mon_pend_o` and `mon_step_o` are 0.
- R3: A `sys_rst_i` pulse leaves the register contents unchanged.
- R4: A `core_rst_i` pulse clears bits 19..16 and keeps the other bits. It also takes priority over a write in the same cycle for those four bits.
- R5: `mon_pend_o` equals bit 17. `mon_step_o` equals bit 18 only while bit 16 (monitor enable) is 1, and is 0 otherwise.
- R6: With `HAS_TRACE`=1, `trace_en_o` follows bit 24. With `HAS_TRACE`=0, bit 24 ignores writes, reads 0, and `trace_en_o` stays 0.
- R7: `fault_i[k]` together with `exc_entry_i` is caught when register bit k+4 is set. The mapping is k=0 memory management, 1 no coprocessor, 2 check, 3 state, 4 bus, 5 interrupt error, 6 hard fault. A catch raises `halt_req_o` one cycle later. A `core_rst_i` pulse is caught when bit 0 is set. A fault whose own enable bit is clear raises no halt.
- R8: `halt_req_o` stays high until a cycle in which `boundary_i` is high, and is low from the following cycle.
- R9: When `vec_fault_i` is high while `halt_req_o` is high, `halt_fault_o` rises the next cycle. It stays high until the halt request clears.
- R10: `late_suppress_o` is high in exactly the cycles where `halt_req_o`, `vec_fault_i` and `late_irq_i` are all high.
- R11: A `sys_rst_i` pulse drops a pending halt request, unless a catch occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | System reset pulse, synchronous |
| core_rst_i | input | 1 | Core reset pulse, synchronous; also a catch event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| exc_entry_i | input | 1 | Exception entry this cycle |
| fault_i | input | 7 | Fault class of the entered exception |
| boundary_i | input | 1 | Instruction boundary strobe |
| vec_fault_i | input | 1 | Fault during vector fetch or stack push |
| late_irq_i | input | 1 | Late-arriving interrupt |
| halt_req_o | output | 1 | Halt request to the core |
| halt_fault_o | output | 1 | Halt retargeted to a vector or stack-push fault handler |
| late_suppress_o | output | 1 | Suppress the late-arrival optimisation |
| trace_en_o | output | 1 | Trace and debug units enable |
| mon_pend_o | output | 1 | Monitor pend |
| mon_step_o | output | 1 | Monitor step, gated by monitor enable |

## Verification
The bench builds two copies of the block side by side from the same stimulus: one with `HAS_TRACE`=1 and one with `HAS_TRACE`=0. This puts both the settable and the hard-wired trace bit within reach. A walking-one write over all 32 bit positions checks the write mask of each copy. A sweep over every combination of the four monitor bits checks the step gating. Every one of the seven fault classes is run with its own enable set, and again with all other enables set instead, which confirms the bit mapping.

// File: rtl/dbg_vc_pkg.sv
package dbg_vc_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_FLT    = 7;
  localparam int VC_CORE_B  = 0;
  localparam int VC_FLT_LO  = 4;
  localparam int MON_EN_B   = 16;
  localparam int MON_PEND_B = 17;
  localparam int MON_STEP_B = 18;
  localparam int MON_REQ_B  = 19;
  localparam int TRC_B      = 24;

  localparam logic [REG_W-1:0] MON_MASK = REG_W'(4'hF) << MON_EN_B;

  function automatic logic [REG_W-1:0] wr_mask(bit has_trace);
    logic [REG_W-1:0] m;
    m = MON_MASK;
    m[VC_CORE_B] = 1'b1;
    for (int i = 0; i < NUM_FLT; i++) m[VC_FLT_LO+i] = 1'b1;
    m[TRC_B] = has_trace;
    return m;
  endfunction
endpackage

// File: rtl/dbg_vc_regs.sv
module dbg_vc_regs
  import dbg_vc_pkg::*;
#(
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_rst_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             trace_en_o,
  output logic             mon_pend_o,
  output logic             mon_step_o
);
  localparam logic [REG_W-1:0] WMASK = wr_mask(HAS_TRACE);

  logic [REG_W-1:0] q;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (WMASK[i]) begin : g_ff
      localparam bit CORE_CLR = MON_MASK[i];
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  b_q <= 1'b0;
        else if (CORE_CLR && core_rst_i) b_q <= 1'b0;
        else if (wr_i)                b_q <= wdata_i[i];
      end
      assign q[i] = b_q;
    end else begin : g_rsvd
      assign q[i] = 1'b0;
    end
  end

  assign rdata_o    = q;
  assign trace_en_o = q[TRC_B];
  assign mon_pend_o = q[MON_PEND_B];
  assign mon_step_o = q[MON_STEP_B] & q[MON_EN_B];
endmodule

// File: rtl/dbg_vc_halt.sv
module dbg_vc_halt
  import dbg_vc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sys_rst_i,
  input  logic               core_rst_i,
  input  logic               exc_entry_i,
  input  logic [NUM_FLT-1:0] fault_i,
  input  logic [NUM_FLT-1:0] vc_en_i,
  input  logic               vc_core_i,
  input  logic               boundary_i,
  input  logic               vec_fault_i,
  input  logic               late_irq_i,
  output logic               halt_req_o,
  output logic               halt_fault_o,
  output logic               late_suppress_o
);
  logic hit, pend_q, pend_d, flt_q, flt_d;

  assign hit = (core_rst_i & vc_core_i) | (exc_entry_i & |(fault_i & vc_en_i));

  always_comb begin
    pend_d = pend_q;
    if (hit)                        pend_d = 1'b1;
    else if (sys_rst_i)             pend_d = 1'b0;
    else if (pend_q && boundary_i)  pend_d = 1'b0;

    flt_d = flt_q;
    if (!pend_d)                    flt_d = 1'b0;
    else if (pend_q && vec_fault_i) flt_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flt_q  <= flt_d;
    end
  end

  assign halt_req_o      = pend_q;
  assign halt_fault_o    = flt_q;
  // late arrival must not preempt a caught exception whose vector/stack access faults
  assign late_suppress_o = pend_q & vec_fault_i & late_irq_i;
endmodule

// File: rtl/dbg_vcatch_ctrl.sv
module dbg_vcatch_ctrl
  import dbg_vc_pkg::*;
#(
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sys_rst_i,
  input  logic               core_rst_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               exc_entry_i,
  input  logic [NUM_FLT-1:0] fault_i,
  input  logic               boundary_i,
  input  logic               vec_fault_i,
  input  logic               late_irq_i,
  output logic               halt_req_o,
  output logic               halt_fault_o,
  output logic               late_suppress_o,
  output logic               trace_en_o,
  output logic               mon_pend_o,
  output logic               mon_step_o
);
  logic [REG_W-1:0] rdata;

  dbg_vc_regs #(.HAS_TRACE(HAS_TRACE)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_rst_i (core_rst_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (rdata),
    .trace_en_o (trace_en_o),
    .mon_pend_o (mon_pend_o),
    .mon_step_o (mon_step_o)
  );

  dbg_vc_halt u_halt (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sys_rst_i       (sys_rst_i),
    .core_rst_i      (core_rst_i),
    .exc_entry_i     (exc_entry_i),
    .fault_i         (fault_i),
    .vc_en_i         (rdata[VC_FLT_LO +: NUM_FLT]),
    .vc_core_i       (rdata[VC_CORE_B]),
    .boundary_i      (boundary_i),
    .vec_fault_i     (vec_fault_i),
    .late_irq_i      (late_irq_i),
    .halt_req_o      (halt_req_o),
    .halt_fault_o    (halt_fault_o),
    .late_suppress_o (late_suppress_o)
  );

  assign reg_rdata_o = rdata;
endmodule

// File: rtl/dbg_vc_checker.sv
module dbg_vc_checker
  import dbg_vc_pkg::*;
#(
  parameter bit HAS_TRACE = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sys_rst_i,
  input logic               core_rst_i,
  input logic               reg_wr_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic [REG_W-1:0]   reg_rdata_o,
  input logic               exc_entry_i,
  input logic               boundary_i,
  input logic               vec_fault_i,
  input logic               late_irq_i,
  input logic               halt_req_o,
  input logic               halt_fault_o,
  input logic               late_suppress_o,
  input logic               trace_en_o,
  input logic               mon_step_o
);
  localparam logic [REG_W-1:0] M = wr_mask(HAS_TRACE);

  a_r1_write_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !core_rst_i |=> reg_rdata_o == ($past(reg_wdata_i) & M));
  a_r3_sys_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i && !reg_wr_i && !core_rst_i |=> $stable(reg_rdata_o));
  a_r4_core_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_i |=> reg_rdata_o[MON_REQ_B:MON_EN_B] == 4'h0);
  a_r5_step_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_step_o |-> reg_rdata_o[MON_EN_B] && reg_rdata_o[MON_STEP_B]);
  a_r6_no_trace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_TRACE |-> !trace_en_o && !reg_rdata_o[TRC_B]);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && !boundary_i && !sys_rst_i |=> halt_req_o);
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && boundary_i && !exc_entry_i && !core_rst_i |=> !halt_req_o);
  a_r9_fault_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && vec_fault_i && !boundary_i && !sys_rst_i |=> halt_fault_o);
  a_r9_fault_only_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_fault_o |-> halt_req_o);
  a_r10_suppress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_suppress_o == (halt_req_o && vec_fault_i && late_irq_i));
endmodule

bind dbg_vcatch_ctrl dbg_vc_checker #(.HAS_TRACE(HAS_TRACE)) u_chk (.*);

// File: tb/dbg_vcatch_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_vcatch_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_rst_i = 1'b0, core_rst_i = 1'b0, reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        exc_entry_i = 1'b0;
  logic [6:0]  fault_i = '0;
  logic        boundary_i = 1'b0, vec_fault_i = 1'b0, late_irq_i = 1'b0;

  logic [31:0] rd_a, rd_b;
  logic        halt_a, hf_a, sup_a, trc_a, pend_a, step_a;
  logic        halt_b, hf_b, sup_b, trc_b, pend_b, step_b;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] MASK_T = 32'h0100_0000 | 32'h000F_0000 | (32'h7F << 4) | 32'h1;
  localparam logic [31:0] MASK_N = MASK_T & ~32'h0100_0000;

  always #2.5 clk_i = ~clk_i;

  dbg_vcatch_ctrl #(.HAS_TRACE(1'b1)) dut_i (
    .clk_i, .rst_ni, .sys_rst_i, .core_rst_i, .reg_wr_i, .reg_wdata_i,
    .reg_rdata_o(rd_a), .exc_entry_i, .fault_i, .boundary_i, .vec_fault_i, .late_irq_i,
    .halt_req_o(halt_a), .halt_fault_o(hf_a), .late_suppress_o(sup_a),
    .trace_en_o(trc_a), .mon_pend_o(pend_a), .mon_step_o(step_a));

  dbg_vcatch_ctrl #(.HAS_TRACE(1'b0)) dut_nt_i (
    .clk_i, .rst_ni, .sys_rst_i, .core_rst_i, .reg_wr_i, .reg_wdata_i,
    .reg_rdata_o(rd_b), .exc_entry_i, .fault_i, .boundary_i, .vec_fault_i, .late_irq_i,
    .halt_req_o(halt_b), .halt_fault_o(hf_b), .late_suppress_o(sup_b),
    .trace_en_o(trc_b), .mon_pend_o(pend_b), .mon_step_o(step_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d; cyc(); reg_wr_i = 1'b0;
  endtask

  task automatic catch_flt(input int k);
    exc_entry_i = 1'b1; fault_i = 7'(1 << k); cyc(); exc_entry_i = 1'b0; fault_i = '0;
  endtask

  task automatic release_halt();
    boundary_i = 1'b1; cyc(); boundary_i = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #7;
    // R2 reset state
    chk("R2 rdata", rd_a, 32'h0);
    chk("R2 outs", {halt_a, hf_a, trc_a, pend_a, step_a}, 32'h0);
    rst_ni = 1'b1; cyc();

    // R1 walking one over every bit, both builds
    for (int i = 0; i < 32; i++) begin
      wr(32'h1 << i);
      chk("R1 mask trace", rd_a, (32'h1 << i) & MASK_T);
      chk("R1 R6 mask notrace", rd_b, (32'h1 << i) & MASK_N);
    end
    wr(32'hFFFF_FFFF);
    chk("R1 all ones", rd_a, MASK_T);

    // R6 trace enable
    wr(32'h0100_0000);
    chk("R6 trace on", {31'b0, trc_a}, 32'h1);
    chk("R6 trace absent", {31'b0, trc_b}, 32'h0);
    wr(32'h0);
    chk("R6 trace off", {31'b0, trc_a}, 32'h0);

    // R5 monitor bits sweep
    for (int v = 0; v < 16; v++) begin
      wr(32'(v) << 16);
      chk("R5 step", {31'b0, step_a}, 32'((v >> 2) & (v & 1)));
      chk("R5 pend", {31'b0, pend_a}, 32'((v >> 1) & 1));
    end

    // R7 R8 per fault class
    for (int k = 0; k < 7; k++) begin
      for (int en = 0; en < 2; en++) begin
        wr(en == 1 ? (32'h1 << (k + 4)) : (32'h7F0 & ~(32'h1 << (k + 4))));
        catch_flt(k);
        chk("R7 catch", {31'b0, halt_a}, 32'(en));
        if (en == 1) begin
          cyc();
          chk("R8 hold", {31'b0, halt_a}, 32'h1);
          boundary_i = 1'b1; #1;
          chk("R8 at boundary", {31'b0, halt_a}, 32'h1);
          cyc(); boundary_i = 1'b0;
          chk("R8 cleared", {31'b0, halt_a}, 32'h0);
        end
      end
    end

    // R4 core reset clears monitor bits, core reset catch
    wr(32'hFFFF_FFFF);
    core_rst_i = 1'b1; cyc(); core_rst_i = 1'b0;
    chk("R4 core clears", rd_a, MASK_T & ~32'h000F_0000);
    chk("R7 core catch", {31'b0, halt_a}, 32'h1);
    release_halt();
    wr(32'h000F_0000);
    core_rst_i = 1'b1; cyc(); core_rst_i = 1'b0;
    chk("R7 core catch off", {31'b0, halt_a}, 32'h0);
    reg_wr_i = 1'b1; reg_wdata_i = 32'h010F_0010; core_rst_i = 1'b1; cyc();
    reg_wr_i = 1'b0; core_rst_i = 1'b0;
    chk("R4 wins over write", rd_a, 32'h0100_0010);

    // R3 system reset keeps register, R11 drops pending halt
    wr(32'hFFFF_FFFF);
    sys_rst_i = 1'b1; cyc(); sys_rst_i = 1'b0;
    chk("R3 keep trace", rd_a, MASK_T);
    chk("R3 keep notrace", rd_b, MASK_N);
    catch_flt(6);
    chk("R11 pending", {31'b0, halt_a}, 32'h1);
    sys_rst_i = 1'b1; cyc(); sys_rst_i = 1'b0;
    chk("R11 dropped", {31'b0, halt_a}, 32'h0);

    // R9 R10 vector fault and late arrival
    catch_flt(6);
    vec_fault_i = 1'b1; late_irq_i = 1'b1; #1;
    chk("R10 suppress", {31'b0, sup_a}, 32'h1);
    cyc(); vec_fault_i = 1'b0; #1;
    chk("R10 no fault", {31'b0, sup_a}, 32'h0);
    chk("R9 retarget", {31'b0, hf_a}, 32'h1);
    cyc();
    chk("R9 held", {31'b0, hf_a}, 32'h1);
    release_halt();
    chk("R9 cleared", {30'b0, hf_a, halt_a}, 32'h0);
    vec_fault_i = 1'b1; #1;
    chk("R10 idle", {31'b0, sup_a}, 32'h0);
    cyc(); vec_fault_i = 1'b0;
    chk("R9 idle", {31'b0, hf_a}, 32'h0);
    late_irq_i = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule